// File: doc/BRIEF.md
# I2C Condition Detector and Clock Hold

This block is the two-wire bus support logic that sits beside a serial shift engine. It brings the open-drain SCL and SDA pin levels into the clock domain through a two-stage synchronizer. On those synchronized samples it recognises START and STOP conditions and keeps sticky status flags for each. It watches for a lost arbitration, and it stretches the bus clock: while the shift engine reports its bit counter as done and software has not released the clock, the block asserts a pull-down enable for SCL.

The block never drives a line high. Its only pin-facing output is a pull-low enable, and a pad wrapper turns that into an open-drain driver. Software sets a release bit to let SCL return to its idle high level. Every detected START clears that bit again, so the next completed transfer stretches the clock once more. A START can also raise an interrupt. The STOP flag clears on its own when a nonzero bit count is loaded, unless the auto-clear inhibit bit is set.

Top module: `i2c_cond_hold`

## Requirements
- R1: After the synchronous reset `rst`, every output is 0.
- R2: A START condition (synchronized SDA falls while synchronized SCL stays high) sets `start_flag_o`, visible three clock edges after the pin change. A one-cycle `start_clr_i` pulse clears the flag, and a START detected in the same cycle wins over the clear.
- R3: `start_irq_o` is high exactly when `start_flag_o` is high and `start_ie_i` is 1, and it follows changes of `start_ie_i` one edge later.
- R4: A `rel_wr_i` pulse loads `rel_wr_val_i` into the release bit, which `scl_rel_o` shows one edge later. A detected START clears the release bit, and it wins over a write in the same cycle.
- R5: In bus mode, with `done_flag_i` = 1 and the release bit 0, `scl_pull_lo_o` is 1 one edge later.
- R6: While the release bit is 1, `scl_pull_lo_o` is 0, whatever `done_flag_i` is.
- R7: A STOP condition (synchronized SDA rises while synchronized SCL stays high) sets `stop_flag_o` three edges after the pin change. SDA edges made while SCL is low set neither flag.
- R8: A `cnt_load_i` pulse with a nonzero `cnt_load_val_i` and `auto_clr_dis_i` = 0 clears `stop_flag_o`. A load of zero, or a load while `auto_clr_dis_i` = 1, leaves the flag set.
- R9: `arb_lost_o` sets when synchronized SCL rises while synchronized SDA is low and `sda_drive_lo_i` = 0. It stays set until a software reset. A rise with `sda_drive_lo_i` = 1 does not set it.
- R10: With `i2c_en_i` = 0, no START or STOP is detected and `scl_pull_lo_o` stays 0.
- R11: While `sw_reset_i` = 1, the START, STOP and arbitration flags, the release bit and the pull-down are all cleared one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_pin_i | input | 1 | Raw SCL pin level |
| sda_pin_i | input | 1 | Raw SDA pin level |
| i2c_en_i | input | 1 | Bus mode enable |
| sw_reset_i | input | 1 | Software reset control bit |
| done_flag_i | input | 1 | Bit counter done flag from the shift engine |
| cnt_load_i | input | 1 | Bit count load strobe |
| cnt_load_val_i | input | CNT_W | Bit count value being loaded |
| auto_clr_dis_i | input | 1 | 1 inhibits the STOP auto-clear on load |
| rel_wr_i | input | 1 | Release bit write strobe |
| rel_wr_val_i | input | 1 | Value written to the release bit |
| start_clr_i | input | 1 | Software clear of the START flag |
| start_ie_i | input | 1 | START interrupt enable |
| sda_drive_lo_i | input | 1 | 1 while the shifter pulls SDA low |
| scl_pull_lo_o | output | 1 | SCL pull-down enable (open-drain) |
| scl_rel_o | output | 1 | Current release bit |
| start_flag_o | output | 1 | START received flag |
| stop_flag_o | output | 1 | STOP received flag |
| arb_lost_o | output | 1 | Arbitration lost flag |
| start_irq_o | output | 1 | START interrupt request |

## Verification
The assertions hold some rules on every cycle. The pull-down never coexists with a set release bit. The interrupt never appears without the START flag. A newly risen START flag always comes with a cleared release bit. Arbitration loss stays set until a software reset. Bus-mode disable and software reset are honoured one edge later. Only the bench scenarios can show the pin-level behaviour: the synchronizer latency, the three-edge detection timing, SDA edges ignored while SCL is low, the auto-clear conditions on count loads, and the arbitration rule for a line the block releases against one it pulls low.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int N_LINES  = 2;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } cond_evt_t;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_cond_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      scl_i,
  input  logic      sda_i,
  output cond_evt_t evt_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // Conditions need SCL high across both samples of the SDA edge.
  always_comb begin
    evt_o.start    = scl_q & scl_i & sda_q & ~sda_i;
    evt_o.stop     = scl_q & scl_i & ~sda_q & sda_i;
    evt_o.scl_rise = ~scl_q & scl_i;
  end
endmodule

// File: rtl/i2c_hold_status.sv
module i2c_hold_status
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             swrst_i,
  input  cond_evt_t        evt_i,
  input  logic             sda_now_i,
  input  logic             sda_drive_lo_i,
  input  logic             done_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             auto_clr_dis_i,
  input  logic             rel_wr_i,
  input  logic             rel_wr_val_i,
  input  logic             start_clr_i,
  input  logic             start_ie_i,
  output logic             pull_lo_o,
  output logic             rel_o,
  output logic             start_o,
  output logic             stop_o,
  output logic             arb_o,
  output logic             irq_o
);
  logic act;
  logic start_d, stop_d, arb_d, rel_d, pull_d, irq_d;
  logic start_q, stop_q, arb_q, rel_q, pull_q, irq_q;

  assign act = en_i & ~swrst_i;

  always_comb begin
    start_d = start_q;
    if (swrst_i)                  start_d = 1'b0;
    else if (act && evt_i.start)  start_d = 1'b1;
    else if (start_clr_i)         start_d = 1'b0;

    stop_d = stop_q;
    if (swrst_i)                  stop_d = 1'b0;
    else if (act && evt_i.stop)   stop_d = 1'b1;
    else if (cnt_load_i && (cnt_val_i != '0) && !auto_clr_dis_i) stop_d = 1'b0;

    arb_d = arb_q;
    if (swrst_i) arb_d = 1'b0;
    else if (act && evt_i.scl_rise && !sda_now_i && !sda_drive_lo_i) arb_d = 1'b1;

    rel_d = rel_q;
    if (swrst_i)                  rel_d = 1'b0;
    else if (act && evt_i.start)  rel_d = 1'b0;
    else if (rel_wr_i)            rel_d = rel_wr_val_i;

    pull_d = act & done_i & ~rel_d;
    irq_d  = start_d & start_ie_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      arb_q   <= 1'b0;
      rel_q   <= 1'b0;
      pull_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      stop_q  <= stop_d;
      arb_q   <= arb_d;
      rel_q   <= rel_d;
      pull_q  <= pull_d;
      irq_q   <= irq_d;
    end
  end

  assign pull_lo_o = pull_q;
  assign rel_o     = rel_q;
  assign start_o   = start_q;
  assign stop_o    = stop_q;
  assign arb_o     = arb_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/i2c_cond_hold.sv
module i2c_cond_hold
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_pin_i,
  input  logic             sda_pin_i,
  input  logic             i2c_en_i,
  input  logic             sw_reset_i,
  input  logic             done_flag_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_load_val_i,
  input  logic             auto_clr_dis_i,
  input  logic             rel_wr_i,
  input  logic             rel_wr_val_i,
  input  logic             start_clr_i,
  input  logic             start_ie_i,
  input  logic             sda_drive_lo_i,
  output logic             scl_pull_lo_o,
  output logic             scl_rel_o,
  output logic             start_flag_o,
  output logic             stop_flag_o,
  output logic             arb_lost_o,
  output logic             start_irq_o
);
  logic [N_LINES-1:0] pins_raw, pins_sync;
  cond_evt_t evt;

  assign pins_raw[LINE_SCL] = scl_pin_i;
  assign pins_raw[LINE_SDA] = sda_pin_i;

  i2c_pin_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk (clk), .rst (rst), .d_i (pins_raw), .q_o (pins_sync)
  );

  i2c_cond_detect u_det (
    .clk   (clk),
    .rst   (rst),
    .scl_i (pins_sync[LINE_SCL]),
    .sda_i (pins_sync[LINE_SDA]),
    .evt_o (evt)
  );

  i2c_hold_status #(.CNT_W(CNT_W)) u_stat (
    .clk            (clk),
    .rst            (rst),
    .en_i           (i2c_en_i),
    .swrst_i        (sw_reset_i),
    .evt_i          (evt),
    .sda_now_i      (pins_sync[LINE_SDA]),
    .sda_drive_lo_i (sda_drive_lo_i),
    .done_i         (done_flag_i),
    .cnt_load_i     (cnt_load_i),
    .cnt_val_i      (cnt_load_val_i),
    .auto_clr_dis_i (auto_clr_dis_i),
    .rel_wr_i       (rel_wr_i),
    .rel_wr_val_i   (rel_wr_val_i),
    .start_clr_i    (start_clr_i),
    .start_ie_i     (start_ie_i),
    .pull_lo_o      (scl_pull_lo_o),
    .rel_o          (scl_rel_o),
    .start_o        (start_flag_o),
    .stop_o         (stop_flag_o),
    .arb_o          (arb_lost_o),
    .irq_o          (start_irq_o)
  );
endmodule

// File: rtl/i2c_cond_hold_chk.sv
module i2c_cond_hold_chk (
  input logic clk,
  input logic rst,
  input logic i2c_en_i,
  input logic sw_reset_i,
  input logic scl_pull_lo_o,
  input logic scl_rel_o,
  input logic start_flag_o,
  input logic stop_flag_o,
  input logic arb_lost_o,
  input logic start_irq_o
);
  a_r6_no_pull_when_released: assert property (@(posedge clk) disable iff (rst)
    scl_pull_lo_o |-> !scl_rel_o);

  a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    start_irq_o |-> start_flag_o);

  a_r4_start_clears_release: assert property (@(posedge clk) disable iff (rst)
    $rose(start_flag_o) |-> !scl_rel_o);

  a_r9_arb_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(arb_lost_o) && !$past(sw_reset_i)) |-> arb_lost_o);

  a_r10_no_pull_disabled: assert property (@(posedge clk) disable iff (rst)
    $past(!i2c_en_i) |-> !scl_pull_lo_o);

  a_r11_swreset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(sw_reset_i) |-> (!start_flag_o && !stop_flag_o && !arb_lost_o
                           && !scl_pull_lo_o && !scl_rel_o));
endmodule

bind i2c_cond_hold i2c_cond_hold_chk u_chk (.*);

// File: tb/tb_i2c_cond_hold.sv
module tb_i2c_cond_hold;
  localparam int CNT_W = 5;
  localparam int S_PULL = 0, S_START = 1, S_STOP = 2, S_ARB = 3, S_IRQ = 4, S_REL = 5;

  typedef struct {
    int    cyc;
    int    sel;
    logic  exp;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_pin = 1'b1, sda_pin = 1'b1;
  logic i2c_en = 1'b0, sw_reset = 1'b0, done_flag = 1'b0;
  logic cnt_load = 1'b0;
  logic [CNT_W-1:0] cnt_val = '0;
  logic auto_clr_dis = 1'b0, rel_wr = 1'b0, rel_val = 1'b0;
  logic start_clr = 1'b0, start_ie = 1'b0, sda_drive_lo = 1'b0;
  logic pull_lo, rel, start_f, stop_f, arb, irq;

  int cyc_cnt = 0;
  int checks = 0;
  int errors = 0;
  exp_t sb[$];

  always #10 clk = ~clk;

  i2c_cond_hold #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .scl_pin_i(scl_pin), .sda_pin_i(sda_pin),
    .i2c_en_i(i2c_en), .sw_reset_i(sw_reset), .done_flag_i(done_flag),
    .cnt_load_i(cnt_load), .cnt_load_val_i(cnt_val), .auto_clr_dis_i(auto_clr_dis),
    .rel_wr_i(rel_wr), .rel_wr_val_i(rel_val), .start_clr_i(start_clr),
    .start_ie_i(start_ie), .sda_drive_lo_i(sda_drive_lo),
    .scl_pull_lo_o(pull_lo), .scl_rel_o(rel), .start_flag_o(start_f),
    .stop_flag_o(stop_f), .arb_lost_o(arb), .start_irq_o(irq)
  );

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic logic actual(int sel);
    case (sel)
      S_PULL:  return pull_lo;
      S_START: return start_f;
      S_STOP:  return stop_f;
      S_ARB:   return arb;
      S_IRQ:   return irq;
      default: return rel;
    endcase
  endfunction

  // Driver side: expect value on signal sel after n more rising edges.
  task automatic expect_after(int n, int sel, logic e, string req);
    exp_t it;
    it.cyc = cyc_cnt + n; it.sel = sel; it.exp = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare due items away from the active edge.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc_cnt) begin
        checks++;
        if (actual(sb[i].sel) !== sb[i].exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%b expected=%b cycle=%0d",
                   sb[i].req, sb[i].sel, actual(sb[i].sel), sb[i].exp, cyc_cnt);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    for (int s = 0; s < 6; s++) expect_after(1, s, 1'b0, "R1");
    wait_n(2);

    // Release bit write, then START clears it and sets the flag
    i2c_en = 1'b1; rel_wr = 1'b1; rel_val = 1'b1;
    expect_after(1, S_REL, 1'b1, "R4");
    wait_n(1); rel_wr = 1'b0;
    wait_n(2);
    sda_pin = 1'b0;
    expect_after(3, S_START, 1'b1, "R2");
    expect_after(3, S_REL, 1'b0, "R4");
    expect_after(3, S_IRQ, 1'b0, "R3");
    wait_n(4);
    start_ie = 1'b1;
    expect_after(1, S_IRQ, 1'b1, "R3");
    wait_n(1);
    start_clr = 1'b1;
    expect_after(1, S_START, 1'b0, "R2");
    expect_after(1, S_IRQ, 1'b0, "R3");
    wait_n(1); start_clr = 1'b0;

    // Clock hold and release
    done_flag = 1'b1;
    expect_after(1, S_PULL, 1'b1, "R5");
    wait_n(2);
    rel_wr = 1'b1; rel_val = 1'b1;
    expect_after(1, S_PULL, 1'b0, "R6");
    expect_after(1, S_REL, 1'b1, "R4");
    wait_n(1); rel_wr = 1'b0;
    wait_n(2);
    expect_after(1, S_PULL, 1'b0, "R6");
    wait_n(1); done_flag = 1'b0;

    // SDA edge while SCL low: no condition
    scl_pin = 1'b0; wait_n(4);
    sda_pin = 1'b1;
    expect_after(3, S_STOP, 1'b0, "R7");
    expect_after(3, S_START, 1'b0, "R7");
    wait_n(4);
    sda_pin = 1'b0; wait_n(4);
    // SCL rise with SDA low while the block pulls SDA: no arbitration loss
    sda_drive_lo = 1'b1; scl_pin = 1'b1;
    expect_after(3, S_ARB, 1'b0, "R9");
    wait_n(4);
    sda_drive_lo = 1'b0;
    sda_pin = 1'b1;
    expect_after(3, S_STOP, 1'b1, "R7");
    wait_n(4);

    // STOP auto-clear rules
    cnt_load = 1'b1; cnt_val = 5'd0;
    expect_after(1, S_STOP, 1'b1, "R8");
    wait_n(1);
    cnt_val = 5'd5; auto_clr_dis = 1'b1;
    expect_after(1, S_STOP, 1'b1, "R8");
    wait_n(1);
    auto_clr_dis = 1'b0;
    expect_after(1, S_STOP, 1'b0, "R8");
    wait_n(1); cnt_load = 1'b0; cnt_val = '0;

    // Arbitration lost
    scl_pin = 1'b0; wait_n(4);
    sda_pin = 1'b0; wait_n(4);
    scl_pin = 1'b1;
    expect_after(3, S_ARB, 1'b1, "R9");
    wait_n(4);

    // Disabled mode
    rel_wr = 1'b1; rel_val = 1'b0;
    expect_after(1, S_REL, 1'b0, "R4");
    wait_n(1); rel_wr = 1'b0;
    i2c_en = 1'b0;
    sda_pin = 1'b1;
    expect_after(3, S_STOP, 1'b0, "R10");
    wait_n(4);
    sda_pin = 1'b0;
    expect_after(3, S_START, 1'b0, "R10");
    wait_n(4);
    done_flag = 1'b1;
    expect_after(1, S_PULL, 1'b0, "R10");
    wait_n(2); done_flag = 1'b0;

    // Software reset clears everything
    i2c_en = 1'b1;
    sda_pin = 1'b1;
    expect_after(3, S_STOP, 1'b1, "R11");
    wait_n(4);
    sda_pin = 1'b0;
    expect_after(3, S_START, 1'b1, "R11");
    wait_n(4);
    done_flag = 1'b1;
    expect_after(1, S_PULL, 1'b1, "R11");
    wait_n(2);
    sw_reset = 1'b1;
    expect_after(1, S_START, 1'b0, "R11");
    expect_after(1, S_STOP, 1'b0, "R11");
    expect_after(1, S_ARB, 1'b0, "R11");
    expect_after(1, S_PULL, 1'b0, "R11");
    expect_after(1, S_REL, 1'b0, "R11");
    expect_after(1, S_IRQ, 1'b0, "R11");
    wait_n(2);
    sw_reset = 1'b0; done_flag = 1'b0;
    wait_n(4);

    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule